// File: doc/BRIEF.md
# PC card bus cycle timing controller

This block sequences the bus cycles for one external card-style memory area. The area is split into a lower and an upper half by the top bit of the area offset. Each half has its own setup count, hold count and coarse low-speed wait code. The area as a whole has one base wait count and one idle-gap count. A request carries an address, a byte or word size, a direction, a burst flag and a DMA flag. The block then drives the two card enables, the read and write strobes and a DMA acknowledge, and it returns a ready pulse for each data beat and a done pulse when the request is complete.

A burst moves 32 bytes. It starts at the requested byte and wraps within the aligned 32-byte block in steps of the bus width: 16 beats on a 16-bit bus, 32 beats on an 8-bit bus. The bus is held for the whole burst, and no idle gap is inserted between its beats. In ATA mode the access type is encoded on the two card enables, and a DMA transfer asserts neither enable. The timing parameters are static inputs.

Top module: `pccard_cycle_ctrl`

## Requirements
- R1: An access whose offset has bit ADDR_W-1 equal to 0 uses setup_a, hold_a and lsw_a. An access with that bit equal to 1 uses setup_b, hold_b and lsw_b.
- R2: Each beat holds its strobe low for base_wait + ext + 1 cycles. ext is 0, 15, 30 or 50 for the selected low-speed wait code 0, 1, 2 or 3.
- R3: Before the first strobe of a request, the enables (or the DMA acknowledge) are active with both strobes high for exactly the selected setup count of cycles (0 to 15).
- R4: After each strobe, the enables stay active with both strobes high for exactly the selected hold count of cycles (0 to 15).
- R5: After the last hold, busy stays high with all enables inactive for idle_gap cycles. This count is the same for both halves.
- R6: With req_burst=1, the block performs 16 beats when bus_16=1 and 32 beats when bus_16=0. Beat k is at address {upper bits of req_addr, (req_addr[4:0] + k*step) mod 32}, where step is 2 or 1. The enables do not drop between beats, and there is no idle gap between them.
- R7: In ATA mode (ata_mode=1), a non-DMA byte access (req_word=0) drives ce2_n low and ce1_n high. A word access (req_word=1) drives ce1_n low and ce2_n high.
- R8: In ATA mode, a DMA request drives neither enable. For every request with req_dma=1, dack is high continuously from the first setup cycle to the last hold cycle of the request.
- R9: Outside ATA mode, ce1_n is low throughout the active cycles. ce2_n is also low when the access is wide: for a single access that means req_word=1, and for a burst it means bus_16=1.
- R10: ready is high on the last strobe cycle of every beat. done is high for one cycle on the last active cycle of the request, and all enables, strobes and dack are inactive on the cycle after it.
- R11: In reset and while idle, busy=0, dack=0, and ce1_n, ce2_n, rd_n and wr_n are all 1.
- R12: A read (req_write=0) pulses only rd_n, and a write pulses only wr_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Area offset of the first datum |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 32-byte wrap-around burst |
| req_dma | input | 1 | DMA transfer |
| bus_16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| ata_mode | input | 1 | ATA enable encoding |
| base_wait | input | 4 | Base wait count for the area |
| idle_gap | input | 4 | Idle cycles after a request |
| lsw_a | input | 2 | Low-speed wait code, lower half |
| setup_a | input | 4 | Setup cycles, lower half |
| hold_a | input | 4 | Hold cycles, lower half |
| lsw_b | input | 2 | Low-speed wait code, upper half |
| setup_b | input | 4 | Setup cycles, upper half |
| hold_b | input | 4 | Hold cycles, upper half |
| busy | output | 1 | A request or its gap is in progress |
| bus_addr | output | ADDR_W | Address of the current beat |
| ce1_n | output | 1 | First card enable, active low |
| ce2_n | output | 1 | Second card enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dack | output | 1 | DMA acknowledge, active high |
| ready | output | 1 | Last strobe cycle of a beat |
| done | output | 1 | Last active cycle of a request |

## Verification
The assertions take for granted that ata_mode, bus_16 and every timing input stay constant while busy is high. They also assume that a request is presented only while the block is idle. The bench changes configuration only between requests, after busy has fallen. It pulses req_valid for a single cycle only when busy is low, so every property's premise holds.

// File: rtl/pccard_cycle_ctrl.sv
module pccard_cycle_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic              req_dma,
  input  logic              bus_16,
  input  logic              ata_mode,
  input  logic [3:0]        base_wait,
  input  logic [3:0]        idle_gap,
  input  logic [1:0]        lsw_a,
  input  logic [3:0]        setup_a,
  input  logic [3:0]        hold_a,
  input  logic [1:0]        lsw_b,
  input  logic [3:0]        setup_b,
  input  logic [3:0]        hold_b,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ce1_n,
  output logic              ce2_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              dack,
  output logic              ready,
  output logic              done
);
  localparam int CW    = 7;
  localparam int BLK_W = 5;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_GAP} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [BLK_W-1:0]  beats_q;
  logic              write_q, wide_q, dma_q, half_b_q;

  logic          cur_b;
  logic [3:0]    sel_setup, sel_hold;
  logic [1:0]    sel_lsw;
  logic [CW-1:0] ext, waits, start_cnt;
  st_t           start_st;
  logic          last_strobe, beat_end, act, strobe;

  assign cur_b     = (st == S_IDLE) ? req_addr[ADDR_W-1] : half_b_q;
  assign sel_setup = cur_b ? setup_b : setup_a;
  assign sel_hold  = cur_b ? hold_b  : hold_a;
  assign sel_lsw   = cur_b ? lsw_b   : lsw_a;

  always_comb begin
    case (sel_lsw)
      2'd0:    ext = CW'(0);
      2'd1:    ext = CW'(15);
      2'd2:    ext = CW'(30);
      default: ext = CW'(50);
    endcase
  end

  assign waits     = CW'(base_wait) + ext;
  assign start_st  = (sel_setup != 4'd0) ? S_SETUP : S_STROBE;
  assign start_cnt = (sel_setup != 4'd0) ? CW'(sel_setup - 4'd1) : waits;

  assign last_strobe = (st == S_STROBE) && (cnt == '0);
  assign beat_end    = (last_strobe && sel_hold == 4'd0) || (st == S_HOLD && cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      beats_q  <= '0;
      write_q  <= 1'b0;
      wide_q   <= 1'b0;
      dma_q    <= 1'b0;
      half_b_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          write_q  <= req_write;
          dma_q    <= req_dma;
          half_b_q <= req_addr[ADDR_W-1];
          wide_q   <= req_burst ? bus_16 : req_word;
          beats_q  <= req_burst ? (bus_16 ? BLK_W'(15) : BLK_W'(31)) : '0;
          st       <= start_st;
          cnt      <= start_cnt;
        end
        S_SETUP: begin
          if (cnt == '0) begin
            st  <= S_STROBE;
            cnt <= waits;
          end else cnt <= cnt - 1'b1;
        end
        S_STROBE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (sel_hold != 4'd0) begin
            st  <= S_HOLD;
            cnt <= CW'(sel_hold - 4'd1);
          end
        end
        S_HOLD: if (cnt != '0) cnt <= cnt - 1'b1;
        S_GAP: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase

      if (beat_end) begin
        if (beats_q != '0) begin
          beats_q            <= beats_q - 1'b1;
          addr_q[BLK_W-1:0]  <= addr_q[BLK_W-1:0] + (wide_q ? BLK_W'(2) : BLK_W'(1));
          st                 <= start_st;
          cnt                <= start_cnt;
        end else if (idle_gap != 4'd0) begin
          st  <= S_GAP;
          cnt <= CW'(idle_gap - 4'd1);
        end else st <= S_IDLE;
      end
    end
  end

  assign act    = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  assign strobe = (st == S_STROBE);

  assign busy     = (st != S_IDLE);
  assign bus_addr = addr_q;
  assign rd_n     = !(strobe && !write_q);
  assign wr_n     = !(strobe && write_q);
  assign ce1_n    = !(act && (ata_mode ? (!dma_q && wide_q)  : 1'b1));
  assign ce2_n    = !(act && (ata_mode ? (!dma_q && !wide_q) : wide_q));
  assign dack     = act && dma_q;
  assign ready    = last_strobe;
  assign done     = beat_end && (beats_q == '0);
endmodule

// File: rtl/pccard_cycle_ctrl_chk.sv
module pccard_cycle_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ata_mode,
  input logic              busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ce1_n,
  input logic              ce2_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              dack,
  input logic              ready,
  input logic              done
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R12
  AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!ce1_n || !ce2_n || dack)); // R3
  AST_ATA_DMA_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_mode && dack) |-> (ce1_n && ce2_n)); // R8
  AST_ATA_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    ata_mode |-> !(!ce1_n && !ce2_n)); // R7
  AST_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!rd_n || !wr_n)); // R10
  AST_DONE_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ce1_n && ce2_n && rd_n && wr_n && !dack)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce1_n && ce2_n && rd_n && wr_n && !dack)); // R11
  AST_ADDR_HELD_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && !ready) |=> $stable(bus_addr)); // R6
endmodule

bind pccard_cycle_ctrl pccard_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pccard_cycle_ctrl_bench.sv
module pccard_cycle_ctrl_bench;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_word = 0, req_write = 0, req_burst = 0, req_dma = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic bus_16 = 0, ata_mode = 0;
  logic [3:0] base_wait = 0, idle_gap = 0, setup_a = 0, hold_a = 0, setup_b = 0, hold_b = 0;
  logic [1:0] lsw_a = 0, lsw_b = 0;
  logic busy, ce1_n, ce2_n, rd_n, wr_n, dack, ready, done;
  logic [ADDR_W-1:0] bus_addr;

  int tests = 0, fails = 0, cycles = 0;
  int pre, strb, mid, gap, nready, ndone, addr_err, done_idx, last_act, dack_cyc;
  int ce1_seen, ce2_seen, rd_seen, wr_seen;

  always #2 clk = ~clk;

  pccard_cycle_ctrl #(.ADDR_W(ADDR_W)) u_pccard_cycle_ctrl (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int ext_of(input logic [1:0] c);
    case (c) 2'd0: return 0; 2'd1: return 15; 2'd2: return 30; default: return 50; endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [ADDR_W-1:0] a, input logic w, input logic wr,
                         input logic b, input logic d);
    int cyc, step, seen;
    logic [4:0] lo;
    pre = 0; strb = 0; mid = 0; gap = 0; nready = 0; ndone = 0; addr_err = 0;
    done_idx = -1; last_act = -1; dack_cyc = 0; ce1_seen = 0; ce2_seen = 0;
    rd_seen = 0; wr_seen = 0; seen = 0; cyc = 0;
    step = (b ? bus_16 : w) ? 2 : 1;
    @(negedge clk);
    req_addr = a; req_word = w; req_write = wr; req_burst = b; req_dma = d; req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    while (busy && cyc < 5000) begin
      if (!rd_n || !wr_n) begin strb++; seen = 1; end
      else if (!seen) pre++;
      else if (!ce1_n || !ce2_n || dack) mid++;
      else gap++;
      if (!ce1_n) ce1_seen = 1;
      if (!ce2_n) ce2_seen = 1;
      if (!rd_n) rd_seen = 1;
      if (!wr_n) wr_seen = 1;
      if (dack) dack_cyc++;
      if (!ce1_n || !ce2_n || dack) last_act = cyc;
      if (ready) begin
        lo = a[4:0] + 5'(nready * step);
        if (bus_addr != {a[ADDR_W-1:5], lo}) addr_err++;
        nready++;
      end
      if (done) begin ndone++; done_idx = cyc; end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R11 busy", busy, 0);
    chk("R11 strobes/enables", {ce1_n, ce2_n, rd_n, wr_n}, 4'hF);
    chk("R11 dack", dack, 0);
  endtask

  task automatic t_single_low;
    ata_mode = 0; bus_16 = 1; base_wait = 2; idle_gap = 4;
    lsw_a = 1; setup_a = 3; hold_a = 2; lsw_b = 3; setup_b = 9; hold_b = 9;
    run_req(16'h0010, 0, 0, 0, 0);
    chk("R1/R3 setup A", pre, 3);
    chk("R2 strobe A code1", strb, 2 + ext_of(1) + 1);
    chk("R4 hold A", mid, 2);
    chk("R5 gap", gap, 4);
    chk("R12 read strobe", {rd_seen[0], wr_seen[0]}, 2'b10);
    chk("R9 byte enables", {ce1_seen[0], ce2_seen[0]}, 2'b10);
    chk("R10 ready count", nready, 1);
    chk("R10 done at end", done_idx, last_act);
    chk("R6 single address", addr_err, 0);
    chk("R11 idle after", {busy, ce1_n, ce2_n, rd_n, wr_n}, 5'b01111);
  endtask

  task automatic t_single_high;
    base_wait = 0; lsw_b = 3; setup_b = 0; hold_b = 0;
    run_req(16'h8004, 1, 1, 0, 0);
    chk("R1/R3 setup B zero", pre, 0);
    chk("R2 strobe B code3", strb, ext_of(3) + 1);
    chk("R4 hold B zero", mid, 0);
    chk("R5 gap shared", gap, 4);
    chk("R12 write strobe", {rd_seen[0], wr_seen[0]}, 2'b01);
    chk("R9 word enables", {ce1_seen[0], ce2_seen[0]}, 2'b11);
    chk("R10 done once", ndone, 1);
  endtask

  task automatic t_lsw2;
    base_wait = 5; lsw_a = 2; setup_a = 15; hold_a = 15; idle_gap = 0;
    run_req(16'h0100, 0, 0, 0, 0);
    chk("R2 strobe code2", strb, 5 + ext_of(2) + 1);
    chk("R3 setup 15", pre, 15);
    chk("R4 hold 15", mid, 15);
    chk("R5 gap zero", gap, 0);
  endtask

  task automatic t_burst16;
    bus_16 = 1; base_wait = 1; lsw_a = 0; setup_a = 1; hold_a = 1; idle_gap = 2;
    run_req(16'h0016, 0, 0, 1, 0);
    chk("R6 beats 16-bit", nready, 16);
    chk("R6 wrap addresses", addr_err, 0);
    chk("R6 strobe total", strb, 16 * 2);
    chk("R6 no gap between beats", mid, 15 * 2 + 1);
    chk("R5 gap after burst", gap, 2);
    chk("R10 burst done once", ndone, 1);
  endtask

  task automatic t_burst8;
    bus_16 = 0; base_wait = 0; lsw_b = 0; setup_b = 0; hold_b = 0; idle_gap = 1;
    run_req(16'h801D, 0, 1, 1, 0);
    chk("R6 beats 8-bit", nready, 32);
    chk("R6 wrap 8-bit", addr_err, 0);
    chk("R6 back-to-back strobes", strb, 32);
    chk("R6 no inner gap", mid, 0);
  endtask

  task automatic t_ata;
    ata_mode = 1; bus_16 = 1; base_wait = 1; setup_a = 2; hold_a = 1; lsw_a = 0; idle_gap = 3;
    run_req(16'h0006, 0, 0, 0, 0);
    chk("R7 ATA byte", {ce1_seen[0], ce2_seen[0]}, 2'b01);
    run_req(16'h0000, 1, 0, 0, 0);
    chk("R7 ATA word", {ce1_seen[0], ce2_seen[0]}, 2'b10);
    run_req(16'h0008, 1, 0, 1, 1);
    chk("R8 ATA DMA no enables", {ce1_seen[0], ce2_seen[0]}, 2'b00);
    chk("R8 dack continuous", dack_cyc, pre + strb + mid);
    chk("R8 dack beats", nready, 16);
    chk("R10 DMA done at end", done_idx, last_act);
    chk("R5 gap after DMA", gap, 3);
    ata_mode = 0;
  endtask

  initial begin
    #1; t_reset;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_single_low;
    t_single_high;
    t_lsw2;
    t_burst16;
    t_burst8;
    t_ata;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule